// File: doc/BRIEF.md
# Keyed Reset Sequencer

This block produces the internal reset events of a small register-based monitoring device. Once the digital supply-good input goes high, it pulls a shared active-low reset pin low through an open-drain driver for a fixed number of clock-enable ticks, then lets the pin go and issues a full power-on reset strobe. After that, the same pin is watched for reset pulses from outside. A pulse that stays low long enough triggers a partial reset. A glitch does not.

Software can also request a partial reset. It has to write a key byte to a dedicated register first and then set the top bit of the control register. A small register file is included so that each reset scope can be seen at the read port. It holds scratch registers that a partial reset clears, limit registers that survive a partial reset, and lockable registers whose write protection also survives a partial reset.

States of the sequencer: `ST_HOLD` drives the pin low and counts ticks toward `POR_TICKS`. On its last tick it moves to `ST_SETTLE` and fires the power-on strobe. `ST_SETTLE` waits until the synchronized pin reads high, then moves to `ST_RUN`. `ST_RUN` moves to `ST_LOW` when the pin is seen low. `ST_LOW` counts ticks while the pin stays low. If the pin goes high first, it returns to `ST_RUN`. If the count reaches `HW_TICKS`, it fires the partial strobe and moves to `ST_TRIP`. `ST_TRIP` waits for the pin to go high and then returns to `ST_RUN`. Loss of supply returns the sequencer to `ST_HOLD` asynchronously.

Top module: `rstseq_top`

## Requirements
- R1: `pin_drive_low` is high while `supply_ok` is low. With `tick` held high, it stays high for exactly `POR_TICKS` clock cycles after `supply_ok` rises, counting the cycle of the rise, and is low from then on.
- R2: `por_strobe` pulses for exactly one cycle per power-up, in the last cycle of the hold. After it, every register reads its default: control 0x00, key 0x00, lock 0x00, scratch register i reads 0xA0+i, limit register i reads 0xC0+i, and lockable register i reads 0x50+i.
- R3: Pin activity that starts while the pin is being driven low is ignored. This holds even if the external low continues past the release. No `part_strobe` results, and the hold length is unchanged.
- R4: With `tick` held high, an external low pulse of W cycles on `pin_in` produces exactly one `part_strobe` when W > `HW_TICKS`, and none when W <= `HW_TICKS`.
- R5: Cycles with `tick` low do not count toward either threshold. A long low pulse made entirely of tick-less cycles causes no reset.
- R6: A partial reset restores the control register, the key register and the scratch registers (addresses 0x10 upward) to their defaults. The limit registers (0x20 upward), the lockable registers (0x30 upward) and the lock bit keep their values.
- R7: Writing a value with bit 7 set to the control register (address 0x00) fires `part_strobe` in the cycle of that write when the last write to the key register (address 0x7B) was 0x6D. Writes to other registers in between do not disarm it. The reset has the R6 scope, and the key reads 0x00 afterwards.
- R8: When the key register does not hold 0x6D, a control write with bit 7 set is an ordinary write. No reset occurs, bits 6:0 are stored, bit 7 reads 0, and the key reads back whatever was last written to it.
- R9: Writing 1 to bit 0 of the lock register (address 0x01) sets a lock bit that only a power-on reset clears. While the lock bit is set, writes to the lockable registers are ignored.
- R10: Reads of unmapped addresses (for example 0x7F) return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| supply_ok | input | 1 | Digital supply-good; low acts as asynchronous reset of the sequencer |
| tick | input | 1 | Clock enable for the time base |
| pin_in | input | 1 | Sampled level of the shared active-low reset pin |
| pin_drive_low | output | 1 | Open-drain enable that pulls the reset pin low |
| por_strobe | output | 1 | One-cycle full reset strobe |
| part_strobe | output | 1 | One-cycle partial reset strobe (pin or software) |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 8 | Register read address |
| rd_data | output | 8 | Register read data, combinational |

## Verification
Pulse width is swept from one cycle up to three cycles past `HW_TICKS`. This separates a pulse that just misses the threshold from one that just meets it. A scratch register and the strobe count are checked after every pulse. Three power-ups are run: one with a quiet pin, one with an external low lying wholly inside the hold, and one with a low that outlasts the release. Together they show that the block ignores its own drive. The software path is tried with a correct key, with no key, with the key overwritten by another value, and with an unrelated write between key and trigger. Each case shows a different way the armed state is kept or lost. Lock, limit and scratch contents are read after partial and full resets to tell the three scopes apart.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

    typedef enum logic [2:0] {
        ST_HOLD   = 3'd0,
        ST_SETTLE = 3'd1,
        ST_RUN    = 3'd2,
        ST_LOW    = 3'd3,
        ST_TRIP   = 3'd4
    } seq_state_e;

    localparam logic [7:0] ADDR_CTRL = 8'h00;
    localparam logic [7:0] ADDR_LOCK = 8'h01;
    localparam logic [7:0] ADDR_KEY  = 8'h7B;
    localparam logic [7:0] SCR_BASE  = 8'h10;
    localparam logic [7:0] LIM_BASE  = 8'h20;
    localparam logic [7:0] LCK_BASE  = 8'h30;

    localparam logic [7:0] KEY_CODE  = 8'h6D;
    localparam logic [7:0] SCR_DEF0  = 8'hA0;
    localparam logic [7:0] LIM_DEF0  = 8'hC0;
    localparam logic [7:0] LCK_DEF0  = 8'h50;

endpackage

// File: rtl/rstseq_sync.sv
module rstseq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    input  logic d_in,
    output logic q_out
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            chain_q <= '1;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d_in};
        end
    end

    assign q_out = chain_q[STAGES-1];
endmodule

// File: rtl/rstseq_fsm.sv
module rstseq_fsm
    import rstseq_pkg::*;
#(
    parameter int POR_TICKS = 1800,
    parameter int HW_TICKS  = 8,
    parameter int CNT_W     = 11
) (
    input  logic             clk,
    input  logic             arst_n,
    input  logic             tick,
    input  logic             pin_s,
    output logic             drive_low,
    output logic             por_fire,
    output logic             hw_fire,
    output seq_state_e       state_q,
    output logic [CNT_W-1:0] cnt_q
);
    localparam logic [CNT_W-1:0] POR_LAST = CNT_W'(POR_TICKS - 1);
    localparam logic [CNT_W-1:0] HW_LAST  = CNT_W'(HW_TICKS - 1);

    seq_state_e       state_d;
    logic [CNT_W-1:0] cnt_d;

    // state register
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            state_q <= ST_HOLD;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_HOLD: begin
                if (tick) begin
                    if (cnt_q == POR_LAST) begin
                        state_d = ST_SETTLE;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            ST_SETTLE: begin
                if (pin_s) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (!pin_s) begin
                    state_d = ST_LOW;
                    cnt_d   = '0;
                end
            end
            ST_LOW: begin
                if (pin_s) begin
                    state_d = ST_RUN;
                end else if (tick) begin
                    if (cnt_q == HW_LAST) begin
                        state_d = ST_TRIP;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            ST_TRIP: begin
                if (pin_s) state_d = ST_RUN;
            end
            default: begin
                state_d = ST_HOLD;
                cnt_d   = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        drive_low = (state_q == ST_HOLD);
        por_fire  = (state_q == ST_HOLD) && tick && (cnt_q == POR_LAST);
        hw_fire   = (state_q == ST_LOW) && !pin_s && tick && (cnt_q == HW_LAST);
    end
endmodule

// File: rtl/rstseq_regs.sv
module rstseq_regs
    import rstseq_pkg::*;
#(
    parameter int NUM_SCR = 4,
    parameter int NUM_LIM = 2,
    parameter int NUM_LCK = 2
) (
    input  logic       clk,
    input  logic       por_fire,
    input  logic       hw_fire,
    input  logic       wr_en,
    input  logic [7:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic [7:0] rd_addr,
    output logic [7:0] rd_data,
    output logic       sw_fire
);
    logic [6:0] ctrl_q;
    logic [7:0] key_q;
    logic       lock_q;
    logic [7:0] scr_q [NUM_SCR];
    logic [7:0] lim_q [NUM_LIM];
    logic [7:0] lck_q [NUM_LCK];
    logic       part_fire;

    assign sw_fire   = wr_en && (wr_addr == ADDR_CTRL) && wr_data[7] && (key_q == KEY_CODE);
    assign part_fire = hw_fire || sw_fire;

    // control, key and lock bit
    always_ff @(posedge clk) begin
        if (por_fire) begin
            ctrl_q <= '0;
            key_q  <= '0;
            lock_q <= 1'b0;
        end else if (part_fire) begin
            ctrl_q <= '0;
            key_q  <= '0;
        end else if (wr_en) begin
            if (wr_addr == ADDR_CTRL) ctrl_q <= wr_data[6:0];
            if (wr_addr == ADDR_KEY)  key_q  <= wr_data;
            if (wr_addr == ADDR_LOCK) lock_q <= lock_q | wr_data[0];
        end
    end

    // scratch: cleared by either reset scope
    for (genvar i = 0; i < NUM_SCR; i++) begin : g_scr
        always_ff @(posedge clk) begin
            if (por_fire || part_fire) begin
                scr_q[i] <= 8'(SCR_DEF0 + i);
            end else if (wr_en && wr_addr == 8'(SCR_BASE + i)) begin
                scr_q[i] <= wr_data;
            end
        end
    end

    // limits: only the full reset restores them
    for (genvar i = 0; i < NUM_LIM; i++) begin : g_lim
        always_ff @(posedge clk) begin
            if (por_fire) begin
                lim_q[i] <= 8'(LIM_DEF0 + i);
            end else if (!part_fire && wr_en && wr_addr == 8'(LIM_BASE + i)) begin
                lim_q[i] <= wr_data;
            end
        end
    end

    // lockable: only the full reset restores them, writes need lock clear
    for (genvar i = 0; i < NUM_LCK; i++) begin : g_lck
        always_ff @(posedge clk) begin
            if (por_fire) begin
                lck_q[i] <= 8'(LCK_DEF0 + i);
            end else if (!part_fire && !lock_q && wr_en && wr_addr == 8'(LCK_BASE + i)) begin
                lck_q[i] <= wr_data;
            end
        end
    end

    // read decode
    always_comb begin
        rd_data = 8'h00;
        if (rd_addr == ADDR_CTRL) rd_data = {1'b0, ctrl_q};
        if (rd_addr == ADDR_KEY)  rd_data = key_q;
        if (rd_addr == ADDR_LOCK) rd_data = {7'b0, lock_q};
        for (int i = 0; i < NUM_SCR; i++) begin
            if (rd_addr == 8'(SCR_BASE + i)) rd_data = scr_q[i];
        end
        for (int i = 0; i < NUM_LIM; i++) begin
            if (rd_addr == 8'(LIM_BASE + i)) rd_data = lim_q[i];
        end
        for (int i = 0; i < NUM_LCK; i++) begin
            if (rd_addr == 8'(LCK_BASE + i)) rd_data = lck_q[i];
        end
    end
endmodule

// File: rtl/rstseq_top.sv
module rstseq_top
    import rstseq_pkg::*;
#(
    parameter int POR_TICKS = 1800,
    parameter int HW_TICKS  = 8,
    parameter int SYNC_STG  = 2,
    parameter int NUM_SCR   = 4,
    parameter int NUM_LIM   = 2,
    parameter int NUM_LCK   = 2
) (
    input  logic       clk,
    input  logic       supply_ok,
    input  logic       tick,
    input  logic       pin_in,
    output logic       pin_drive_low,
    output logic       por_strobe,
    output logic       part_strobe,
    input  logic       wr_en,
    input  logic [7:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic [7:0] rd_addr,
    output logic [7:0] rd_data
);
    localparam int CNT_MAX = (POR_TICKS > HW_TICKS) ? POR_TICKS : HW_TICKS;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    logic             pin_s;
    logic             hw_fire;
    logic             sw_fire;
    seq_state_e       fsm_state;
    logic [CNT_W-1:0] fsm_cnt;

    rstseq_sync #(.STAGES(SYNC_STG)) u_sync (
        .clk    (clk),
        .arst_n (supply_ok),
        .d_in   (pin_in),
        .q_out  (pin_s)
    );

    rstseq_fsm #(
        .POR_TICKS (POR_TICKS),
        .HW_TICKS  (HW_TICKS),
        .CNT_W     (CNT_W)
    ) u_fsm (
        .clk       (clk),
        .arst_n    (supply_ok),
        .tick      (tick),
        .pin_s     (pin_s),
        .drive_low (pin_drive_low),
        .por_fire  (por_strobe),
        .hw_fire   (hw_fire),
        .state_q   (fsm_state),
        .cnt_q     (fsm_cnt)
    );

    rstseq_regs #(
        .NUM_SCR (NUM_SCR),
        .NUM_LIM (NUM_LIM),
        .NUM_LCK (NUM_LCK)
    ) u_regs (
        .clk      (clk),
        .por_fire (por_strobe),
        .hw_fire  (hw_fire),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .sw_fire  (sw_fire)
    );

    assign part_strobe = hw_fire || sw_fire;
endmodule

// File: rtl/rstseq_chk.sv
module rstseq_chk
    import rstseq_pkg::*;
#(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             supply_ok,
    input  logic             tick,
    input  logic             pin_drive_low,
    input  logic             por_strobe,
    input  logic             part_strobe,
    input  logic [7:0]       key_q,
    input  logic             lock_q,
    input  seq_state_e       state_q,
    input  logic [CNT_W-1:0] cnt_q
);
    assert_release_after_por_R1: assert property (@(posedge clk) disable iff (!supply_ok)
        por_strobe |=> !pin_drive_low);

    assert_por_once_R2: assert property (@(posedge clk) disable iff (!supply_ok)
        por_strobe |=> !por_strobe);

    assert_hold_no_part_R3: assert property (@(posedge clk) disable iff (!supply_ok)
        pin_drive_low |-> !part_strobe);

    assert_part_single_R4: assert property (@(posedge clk) disable iff (!supply_ok)
        part_strobe |=> !part_strobe);

    assert_tick_freeze_R5: assert property (@(posedge clk) disable iff (!supply_ok)
        (!tick && state_q == ST_HOLD) |=> (state_q == ST_HOLD && $stable(cnt_q)));

    assert_key_cleared_R7: assert property (@(posedge clk) disable iff (!supply_ok)
        part_strobe |=> (key_q == 8'h00));

    assert_lock_sticky_R9: assert property (@(posedge clk) disable iff (!supply_ok)
        (lock_q && !por_strobe) |=> lock_q);

    assert_scopes_apart_R2: assert property (@(posedge clk) disable iff (!supply_ok)
        !(por_strobe && part_strobe));
endmodule

bind rstseq_top rstseq_chk #(.CNT_W(CNT_W)) u_chk (
    .clk           (clk),
    .supply_ok     (supply_ok),
    .tick          (tick),
    .pin_drive_low (pin_drive_low),
    .por_strobe    (por_strobe),
    .part_strobe   (part_strobe),
    .key_q         (u_regs.key_q),
    .lock_q        (u_regs.lock_q),
    .state_q       (u_fsm.state_q),
    .cnt_q         (u_fsm.cnt_q)
);

// File: tb/rstseq_top_tb.sv
`timescale 1ns/1ps
module rstseq_top_tb;
    localparam int POR = 20;
    localparam int HW  = 5;
    localparam int NS  = 4;
    localparam int NL  = 2;
    localparam int NK  = 2;

    logic       clk = 1'b0;
    logic       supply_ok = 1'b0;
    logic       tick = 1'b1;
    logic       ext_low = 1'b0;
    logic       pin_in;
    logic       pin_drive_low, por_strobe, part_strobe;
    logic       wr_en = 1'b0;
    logic [7:0] wr_addr = 8'h00, wr_data = 8'h00, rd_addr = 8'h00;
    logic [7:0] rd_data;

    int n_checks = 0, n_fail = 0;
    int por_cnt = 0, part_cnt = 0;

    always #2.5 clk = ~clk;

    assign pin_in = !(ext_low || pin_drive_low);

    rstseq_top #(
        .POR_TICKS (POR), .HW_TICKS (HW), .SYNC_STG (2),
        .NUM_SCR (NS), .NUM_LIM (NL), .NUM_LCK (NK)
    ) u_dut (
        .clk (clk), .supply_ok (supply_ok), .tick (tick), .pin_in (pin_in),
        .pin_drive_low (pin_drive_low), .por_strobe (por_strobe),
        .part_strobe (part_strobe), .wr_en (wr_en), .wr_addr (wr_addr),
        .wr_data (wr_data), .rd_addr (rd_addr), .rd_data (rd_data)
    );

    always @(negedge clk) begin
        #1;
        if (supply_ok && por_strobe)  por_cnt++;
        if (supply_ok && part_strobe) part_cnt++;
    end

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_addr = a;
        #1.5;
        d = rd_data;
    endtask

    task automatic power_up(input int ext_len, output int held);
        held = 0;
        supply_ok = 1'b0;
        repeat (3) @(negedge clk);
        supply_ok = 1'b1;
        ext_low = (ext_len > 0);
        for (int i = 0; i < POR + ext_len + 6; i++) begin
            #1;
            if (pin_drive_low) held++;
            if (i + 1 == ext_len) ext_low = 1'b0;
            @(negedge clk);
        end
        ext_low = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic pulse(input int w);
        @(negedge clk);
        ext_low = 1'b1;
        repeat (w) @(negedge clk);
        ext_low = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic check_defaults(input string req);
        logic [7:0] v;
        rd(8'h00, v); check(req, v, 8'h00);
        rd(8'h7B, v); check(req, v, 8'h00);
        rd(8'h01, v); check(req, v, 8'h00);
        for (int i = 0; i < NS; i++) begin rd(8'(8'h10 + i), v); check(req, v, 8'hA0 + i); end
        for (int i = 0; i < NL; i++) begin rd(8'(8'h20 + i), v); check(req, v, 8'hC0 + i); end
        for (int i = 0; i < NK; i++) begin rd(8'(8'h30 + i), v); check(req, v, 8'h50 + i); end
    endtask

    initial begin
        #900us;
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        int held, p0, q0;
        logic [7:0] v;

        // reset state while supply is low
        #1;
        check("R1 drive while unpowered", pin_drive_low, 1);

        // R1 R2: clean power-up
        p0 = por_cnt; q0 = part_cnt;
        power_up(0, held);
        check("R1 hold length", held, POR);
        check("R1 released", pin_drive_low, 0);
        check("R2 one por strobe", por_cnt - p0, 1);
        check_defaults("R2 defaults");
        rd(8'h7F, v); check("R10 unmapped read", v, 8'h00);

        // load non-default contents
        wr(8'h00, 8'h15);
        for (int i = 0; i < NL; i++) wr(8'(8'h20 + i), 8'(8'h60 + i));
        for (int i = 0; i < NK; i++) wr(8'(8'h30 + i), 8'(8'h70 + i));

        // R4 R6: pulse width sweep
        for (int w = 1; w <= HW + 3; w++) begin
            wr(8'h10, 8'h33);
            q0 = part_cnt;
            pulse(w);
            check($sformatf("R4 strobes for width %0d", w), part_cnt - q0, (w > HW) ? 1 : 0);
            rd(8'h10, v);
            check($sformatf("R6 scratch after width %0d", w), v, (w > HW) ? 8'hA0 : 8'h33);
        end
        rd(8'h00, v); check("R6 ctrl cleared", v, 8'h00);
        for (int i = 0; i < NL; i++) begin rd(8'(8'h20 + i), v); check("R6 limit kept", v, 8'h60 + i); end
        for (int i = 0; i < NK; i++) begin rd(8'(8'h30 + i), v); check("R6 lockable kept", v, 8'h70 + i); end

        // R5: no ticks, no counting
        tick = 1'b0;
        q0 = part_cnt;
        pulse(3 * HW);
        check("R5 tickless pulse", part_cnt - q0, 0);
        tick = 1'b1;
        q0 = part_cnt;
        pulse(HW + 2);
        check("R5 ticking pulse after", part_cnt - q0, 1);

        // R8: no key
        q0 = part_cnt;
        wr(8'h00, 8'h85);
        check("R8 no key no strobe", part_cnt - q0, 0);
        rd(8'h00, v); check("R8 plain ctrl write", v, 8'h05);
        // R8: key overwritten
        wr(8'h7B, 8'h6D);
        wr(8'h7B, 8'h12);
        wr(8'h00, 8'h80);
        check("R8 disarmed key", part_cnt - q0, 0);
        rd(8'h7B, v); check("R8 key readback", v, 8'h12);
        rd(8'h00, v); check("R8 ctrl bit7 reads 0", v, 8'h00);

        // R7: armed key, unrelated write between
        wr(8'h10, 8'h44);
        wr(8'h7B, 8'h6D);
        rd(8'h7B, v); check("R7 key stored", v, 8'h6D);
        wr(8'h11, 8'h55);
        q0 = part_cnt;
        wr(8'h00, 8'h83);
        check("R7 software strobe", part_cnt - q0, 1);
        rd(8'h7B, v); check("R7 key cleared", v, 8'h00);
        rd(8'h00, v); check("R7 ctrl cleared", v, 8'h00);
        rd(8'h10, v); check("R7 scratch0 cleared", v, 8'hA0);
        rd(8'h11, v); check("R7 scratch1 cleared", v, 8'hA1);
        rd(8'h20, v); check("R7 limit kept", v, 8'h60);

        // R9: lock
        wr(8'h01, 8'h01);
        wr(8'h30, 8'hEE);
        rd(8'h30, v); check("R9 locked write ignored", v, 8'h70);
        wr(8'h01, 8'h00);
        rd(8'h01, v); check("R9 lock sticky", v, 8'h01);
        pulse(HW + 3);
        rd(8'h01, v); check("R9 lock survives partial", v, 8'h01);

        // R3: external low inside hold, then spanning release
        p0 = por_cnt; q0 = part_cnt;
        power_up(8, held);
        check("R3 hold length with inner pulse", held, POR);
        check("R3 no strobe inner", part_cnt - q0, 0);
        check("R2 one por strobe again", por_cnt - p0, 1);
        check_defaults("R2 defaults after cycle");
        p0 = por_cnt; q0 = part_cnt;
        power_up(POR + 15, held);
        check("R3 hold length with long pulse", held, POR);
        check("R3 no strobe spanning release", part_cnt - q0, 0);
        q0 = part_cnt;
        pulse(HW + 1);
        check("R4 pulse after spanning case", part_cnt - q0, 1);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule